// File: doc/BRIEF.md
# Ping-Pong Data Buffer Controller

This block sits on the device side of a storage interface. It holds two equal data buffers so that the array side can stream a page into one buffer while the host reads out the other. A load begins with a start strobe that names a buffer. The start is taken only if that buffer is idle, and the buffer is then marked busy. Load writes land in the selected buffer at a location given by a sector index and a byte offset. Once the whole buffer has been written, the busy mark drops and an interrupt goes to the host.

The array side attaches two error-correction flags to every load write. The block ORs them over the whole load. When the fill completes, it stores the result in a status word together with the number of the buffer that finished. The host can read either buffer at any time. A read aimed at a buffer that is still being loaded returns whatever that buffer holds and raises a collision flag. The interrupt is cleared by a host clear strobe. In auto-clear mode it is also cleared by the next accepted load start.

Top module: `ppb_ctrl`

## Requirements
- R1: Each of the two buffers holds NUM_SECT*SECT_BYTES bytes (default 4 x 512). A location is addressed as {sector[1:0], offset[8:0]}. A host read issued with rd_en_i returns the byte stored at that location on rd_data_o after the next rising clock edge.
- R2: A load start (ld_start_i, buffer ld_start_buf_i) is accepted only when the named buffer is idle. It then marks that buffer busy and restarts its fill count. A start aimed at a busy buffer is ignored, and the load in progress keeps its count.
- R3: A load write (ld_valid_i) is stored only when the buffer named by ld_buf_i is busy. A write to an idle buffer leaves its contents unchanged.
- R4: A fill completes on the NUM_SECT*SECT_BYTES-th accepted write since the accepted start. The busy mark of that buffer is released at that same clock edge. At most one buffer completes per cycle.
- R5: irq_o rises at the clock edge that accepts the final write of a fill, and at no other time.
- R6: irq_o stays set until a cycle with irq_clr_i high clears it. If a fill completes in the same cycle as a clear, irq_o stays set.
- R7: With auto_clr_i high, an accepted load start also clears irq_o. With auto_clr_i low, a load start leaves irq_o unchanged.
- R8: status_o bit 0 is the OR of ld_ecc_corr_i over the accepted writes of the last completed fill. Bit 1 is the same for ld_ecc_unc_i. Bit 2 is the index of the buffer that completed. status_o changes only at a fill completion.
- R9: rd_collide_o is updated together with rd_data_o. It reads 1 when the read targeted a busy buffer and 0 otherwise. A colliding read still returns the stored byte.
- R10: A host read of one buffer and a load write into the other buffer in the same cycle do not disturb each other. The read returns correct data, and the load's count and contents are unaffected.
- R11: After reset both buffers are idle, and irq_o, status_o and rd_collide_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_start_i | input | 1 | Load start strobe |
| ld_start_buf_i | input | 1 | Buffer named by the load start |
| ld_valid_i | input | 1 | Load write strobe |
| ld_buf_i | input | 1 | Buffer named by the load write |
| ld_sect_i | input | SECT_W (2) | Sector index of the load write |
| ld_off_i | input | OFF_W (9) | Byte offset within the sector |
| ld_data_i | input | DATA_W (8) | Load write data |
| ld_ecc_corr_i | input | 1 | Corrected-error flag for this write |
| ld_ecc_unc_i | input | 1 | Uncorrectable-error flag for this write |
| rd_en_i | input | 1 | Host read strobe |
| rd_buf_i | input | 1 | Buffer named by the host read |
| rd_addr_i | input | ADDR_W (11) | Host read location {sector, offset} |
| rd_data_o | output | DATA_W (8) | Host read data, one cycle after rd_en_i |
| rd_collide_o | output | 1 | Last read targeted a busy buffer |
| irq_o | output | 1 | Fill-complete interrupt |
| irq_clr_i | input | 1 | Host interrupt clear strobe |
| auto_clr_i | input | 1 | Auto-clear mode: accepted start clears irq_o |
| status_o | output | 3 | {buffer index, uncorrectable, corrected} of the last fill |

## Verification
Several properties are checked on every cycle. The interrupt rises only after a fill completion. A clear or an auto-clear start drops it unless a completion coincides, and otherwise it holds. The status word stays still between completions, at most one buffer completes per cycle, and the collision flag follows the busy state of the buffer that was read. Other behaviour can only be shown by the bench's scenarios. These are that exactly the full byte count finishes a load, that a start to a busy buffer leaves the count alone, and that writes to an idle buffer leave its contents alone. The same holds for read data matching what was written while the other buffer is being filled, and for the ECC flags gathered over a load landing in the right status bits.

// File: rtl/ppb_pkg.sv
`timescale 1ns/1ps
package ppb_pkg;

  localparam int unsigned NUM_BUFS = 2;

  typedef struct packed {
    logic buf_id;
    logic unc;
    logic corr;
  } ppb_status_t;

endpackage

// File: rtl/ppb_rst_sync.sv
`timescale 1ns/1ps
module ppb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/ppb_bank.sv
`timescale 1ns/1ps
module ppb_bank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 2048,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_d;

  // storage array: write-only clocked process, no reset
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read register: old contents win when the same word is written
  always_comb begin
    rdata_d = rdata_q;
    if (re) rdata_d = mem[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/ppb_fill_trk.sv
`timescale 1ns/1ps
module ppb_fill_trk #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_hit,
  input  logic wr_hit,
  input  logic ecc_corr,
  input  logic ecc_unc,
  output logic busy_o,
  output logic start_ok_o,
  output logic wr_ok_o,
  output logic done_o,
  output logic done_corr_o,
  output logic done_unc_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q,  cnt_d;
  logic             corr_q, corr_d;
  logic             unc_q,  unc_d;
  logic             start_ok, wr_ok, done;

  always_comb begin
    start_ok = start_hit && !busy_q;
    wr_ok    = wr_hit && busy_q;
    done     = wr_ok && (cnt_q == LAST);

    busy_d = busy_q;
    cnt_d  = cnt_q;
    corr_d = corr_q;
    unc_d  = unc_q;

    if (start_ok) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      corr_d = 1'b0;
      unc_d  = 1'b0;
    end else if (wr_ok) begin
      cnt_d  = cnt_q + 1'b1;
      corr_d = corr_q | ecc_corr;
      unc_d  = unc_q | ecc_unc;
      if (done) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      corr_q <= 1'b0;
      unc_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      corr_q <= corr_d;
      unc_q  <= unc_d;
    end
  end

  assign busy_o      = busy_q;
  assign start_ok_o  = start_ok;
  assign wr_ok_o     = wr_ok;
  assign done_o      = done;
  assign done_corr_o = corr_q | (wr_ok & ecc_corr);
  assign done_unc_o  = unc_q | (wr_ok & ecc_unc);

endmodule

// File: rtl/ppb_irq_stat.sv
`timescale 1ns/1ps
module ppb_irq_stat
  import ppb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fill_any,
  input  logic        fill_buf,
  input  logic        fill_corr,
  input  logic        fill_unc,
  input  logic        start_any,
  input  logic        clr_i,
  input  logic        auto_i,
  output logic        irq_o,
  output ppb_status_t status_o
);

  logic        irq_q, irq_d;
  ppb_status_t stat_q, stat_d;

  always_comb begin
    irq_d  = irq_q;
    stat_d = stat_q;
    if (fill_any) begin
      irq_d         = 1'b1;
      stat_d.buf_id = fill_buf;
      stat_d.unc    = fill_unc;
      stat_d.corr   = fill_corr;
    end else if (clr_i || (auto_i && start_any)) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      irq_q  <= irq_d;
      stat_q <= stat_d;
    end
  end

  assign irq_o    = irq_q;
  assign status_o = stat_q;

endmodule

// File: rtl/ppb_ctrl.sv
`timescale 1ns/1ps
module ppb_ctrl
  import ppb_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SECT_BYTES = 512,
  parameter int unsigned NUM_SECT   = 4,
  localparam int unsigned OFF_W     = $clog2(SECT_BYTES),
  localparam int unsigned SECT_W    = $clog2(NUM_SECT),
  localparam int unsigned ADDR_W    = OFF_W + SECT_W,
  localparam int unsigned BUF_DEPTH = NUM_SECT * SECT_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_start_i,
  input  logic              ld_start_buf_i,
  input  logic              ld_valid_i,
  input  logic              ld_buf_i,
  input  logic [SECT_W-1:0] ld_sect_i,
  input  logic [OFF_W-1:0]  ld_off_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic              ld_ecc_corr_i,
  input  logic              ld_ecc_unc_i,
  input  logic              rd_en_i,
  input  logic              rd_buf_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_collide_o,
  output logic              irq_o,
  input  logic              irq_clr_i,
  input  logic              auto_clr_i,
  output logic [2:0]        status_o
);

  logic rst_sync_n;

  ppb_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  logic [NUM_BUFS-1:0] busy, start_ok, wr_ok, fill_done, fill_corr, fill_unc;
  logic [DATA_W-1:0]   bank_rdata [NUM_BUFS];
  logic [ADDR_W-1:0]   ld_addr;

  assign ld_addr = {ld_sect_i, ld_off_i};

  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_buf
    logic start_hit, wr_hit, rd_hit;

    assign start_hit = ld_start_i && (ld_start_buf_i == 1'(b));
    assign wr_hit    = ld_valid_i && (ld_buf_i == 1'(b));
    assign rd_hit    = rd_en_i && (rd_buf_i == 1'(b));

    ppb_fill_trk #(.DEPTH(BUF_DEPTH)) u_trk (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .start_hit   (start_hit),
      .wr_hit      (wr_hit),
      .ecc_corr    (ld_ecc_corr_i),
      .ecc_unc     (ld_ecc_unc_i),
      .busy_o      (busy[b]),
      .start_ok_o  (start_ok[b]),
      .wr_ok_o     (wr_ok[b]),
      .done_o      (fill_done[b]),
      .done_corr_o (fill_corr[b]),
      .done_unc_o  (fill_unc[b])
    );

    ppb_bank #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) u_bank (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .we    (wr_ok[b]),
      .waddr (ld_addr),
      .wdata (ld_data_i),
      .re    (rd_hit),
      .raddr (rd_addr_i),
      .rdata (bank_rdata[b])
    );
  end

  // completion merge: only one load port, so at most one bit set
  logic fill_any, fill_buf, start_any;

  assign fill_any  = |fill_done;
  assign fill_buf  = fill_done[1];
  assign start_any = |start_ok;

  ppb_status_t stat;

  ppb_irq_stat u_irq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .fill_any  (fill_any),
    .fill_buf  (fill_buf),
    .fill_corr (|(fill_done & fill_corr)),
    .fill_unc  (|(fill_done & fill_unc)),
    .start_any (start_any),
    .clr_i     (irq_clr_i),
    .auto_i    (auto_clr_i),
    .irq_o     (irq_o),
    .status_o  (stat)
  );

  assign status_o = stat;

  // host read side: remember which bank answered and whether it was busy
  logic rd_sel_q, rd_sel_d;
  logic collide_q, collide_d;

  always_comb begin
    rd_sel_d  = rd_sel_q;
    collide_d = collide_q;
    if (rd_en_i) begin
      rd_sel_d  = rd_buf_i;
      collide_d = busy[rd_buf_i];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_sel_q  <= 1'b0;
      collide_q <= 1'b0;
    end else begin
      rd_sel_q  <= rd_sel_d;
      collide_q <= collide_d;
    end
  end

  assign rd_data_o    = bank_rdata[rd_sel_q];
  assign rd_collide_o = collide_q;

endmodule

// File: rtl/ppb_ctrl_chk.sv
`timescale 1ns/1ps
module ppb_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic       irq_clr,
  input logic       auto_clr,
  input logic       fill_any,
  input logic [1:0] fill_vec,
  input logic       start_any,
  input logic [2:0] status,
  input logic       rd_en,
  input logic       rd_buf,
  input logic [1:0] busy,
  input logic       rd_collide
);

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(fill_any)); // R5

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fill_any |=> irq); // R5

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !fill_any) |=> !irq); // R6

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr && !auto_clr && !fill_any) |=> irq); // R6

  AST_IRQ_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_clr && start_any && !fill_any) |=> !irq); // R7

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_any |=> $stable(status)); // R8

  AST_ONE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_vec)); // R4

  AST_FILL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_vec[0] |=> !busy[0]); // R4

  AST_COLLIDE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy[rd_buf]) |=> rd_collide); // R9

  AST_COLLIDE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !busy[rd_buf]) |=> !rd_collide); // R9

endmodule

bind ppb_ctrl ppb_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .irq        (irq_o),
  .irq_clr    (irq_clr_i),
  .auto_clr   (auto_clr_i),
  .fill_any   (fill_any),
  .fill_vec   (fill_done),
  .start_any  (start_any),
  .status     (status_o),
  .rd_en      (rd_en_i),
  .rd_buf     (rd_buf_i),
  .busy       (busy),
  .rd_collide (rd_collide_o)
);

// File: tb/ppb_ctrl_test.sv
`timescale 1ns/1ps
module ppb_ctrl_test;

  localparam int DEPTH = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_start = 1'b0, ld_start_buf = 1'b0;
  logic        ld_valid = 1'b0, ld_buf = 1'b0;
  logic [1:0]  ld_sect = '0;
  logic [8:0]  ld_off = '0;
  logic [7:0]  ld_data = '0;
  logic        ld_corr = 1'b0, ld_unc = 1'b0;
  logic        rd_en = 1'b0, rd_buf = 1'b0;
  logic [10:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        rd_collide, irq;
  logic        irq_clr = 1'b0, auto_clr = 1'b0;
  logic [2:0]  status;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ppb_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .ld_start_i(ld_start), .ld_start_buf_i(ld_start_buf),
    .ld_valid_i(ld_valid), .ld_buf_i(ld_buf), .ld_sect_i(ld_sect),
    .ld_off_i(ld_off), .ld_data_i(ld_data),
    .ld_ecc_corr_i(ld_corr), .ld_ecc_unc_i(ld_unc),
    .rd_en_i(rd_en), .rd_buf_i(rd_buf), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .rd_collide_o(rd_collide),
    .irq_o(irq), .irq_clr_i(irq_clr), .auto_clr_i(auto_clr),
    .status_o(status)
  );

  function automatic logic [7:0] pat(int seed, int b, int a);
    return 8'(((a * 13) + (seed * 29) + (b * 71)) ^ (a >> 3));
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start(int b);
    ld_start = 1'b1; ld_start_buf = b[0];
    @(negedge clk);
    ld_start = 1'b0;
  endtask

  task automatic wr(int b, int a, logic [7:0] d, bit corr, bit unc, bit clr);
    logic [10:0] ad;
    ad = 11'(a);
    ld_valid = 1'b1; ld_buf = b[0];
    ld_sect = ad[10:9]; ld_off = ad[8:0]; ld_data = d;
    ld_corr = corr; ld_unc = unc; irq_clr = clr;
    @(negedge clk);
    ld_valid = 1'b0; ld_corr = 1'b0; ld_unc = 1'b0; irq_clr = 1'b0;
  endtask

  task automatic fill(int b, int seed, int first, int last,
                      int corr_at, int unc_at, bit clr_last);
    for (int a = first; a <= last; a++)
      wr(b, a, pat(seed, b, a), a == corr_at, a == unc_at, clr_last && a == last);
  endtask

  task automatic rd(int b, int a);
    rd_en = 1'b1; rd_buf = b[0]; rd_addr = 11'(a);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic clear_irq();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 irq after reset", int'(irq), 0);
    chk("R11 status after reset", int'(status), 0);
    chk("R11 collide after reset", int'(rd_collide), 0);
  endtask

  task automatic t_fill_basic();
    int addrs [5] = '{0, 511, 512, 1535, 2047};
    auto_clr = 1'b0;
    start(0);
    fill(0, 1, 0, DEPTH - 2, -1, -1, 1'b0);
    chk("R5 no irq before last write", int'(irq), 0);
    fill(0, 1, DEPTH - 1, DEPTH - 1, -1, -1, 1'b0);
    chk("R4 R5 irq on final write", int'(irq), 1);
    chk("R8 status clean buf0", int'(status), 3'b000);
    foreach (addrs[i]) begin
      rd(0, addrs[i]);
      chk("R1 read back buf0", int'(rd_data), int'(pat(1, 0, addrs[i])));
      chk("R4 R9 no collide after fill", int'(rd_collide), 0);
    end
    clear_irq();
    chk("R6 irq cleared by host", int'(irq), 0);
  endtask

  task automatic t_busy_reject();
    start(1);
    fill(1, 1, 0, 99, 50, -1, 1'b0);
    start(1);
    fill(1, 1, 100, DEPTH - 2, 50, -1, 1'b0);
    chk("R2 count kept after rejected start", int'(irq), 0);
    fill(1, 1, DEPTH - 1, DEPTH - 1, -1, -1, 1'b1);
    chk("R2 R6 fill beats clear", int'(irq), 1);
    chk("R8 status corrected buf1", int'(status), 3'b101);
    rd(1, 99);
    chk("R1 read back buf1", int'(rd_data), int'(pat(1, 1, 99)));
  endtask

  task automatic t_idle_write();
    wr(0, 7, ~pat(1, 0, 7), 1'b1, 1'b1, 1'b0);
    wr(1, 2047, ~pat(1, 1, 2047), 1'b0, 1'b0, 1'b0);
    rd(0, 7);
    chk("R3 idle buf0 unchanged", int'(rd_data), int'(pat(1, 0, 7)));
    rd(1, 2047);
    chk("R3 idle buf1 unchanged", int'(rd_data), int'(pat(1, 1, 2047)));
    chk("R8 status unchanged by idle write", int'(status), 3'b101);
    chk("R5 no irq change by idle write", int'(irq), 1);
  endtask

  task automatic t_overlap();
    int ra;
    auto_clr = 1'b0;
    start(0);
    chk("R7 start leaves irq when auto off", int'(irq), 1);
    fill(0, 2, 0, 1023, -1, -1, 1'b0);
    rd(0, 3);
    chk("R9 collide read new data", int'(rd_data), int'(pat(2, 0, 3)));
    chk("R9 collide flag set", int'(rd_collide), 1);
    rd(0, 2000);
    chk("R9 collide read old data", int'(rd_data), int'(pat(1, 0, 2000)));
    chk("R9 collide flag set again", int'(rd_collide), 1);
    for (int a = 1024; a <= DEPTH - 2; a++) begin
      ra = (a * 3) % DEPTH;
      rd_en = 1'b1; rd_buf = 1'b1; rd_addr = 11'(ra);
      wr(0, a, pat(2, 0, a), 1'b0, a == 1500, 1'b0);
      rd_en = 1'b0;
      chk("R10 read other buffer during load", int'(rd_data), int'(pat(1, 1, ra)));
      chk("R10 R9 other buffer no collide", int'(rd_collide), 0);
    end
    chk("R8 status held during load", int'(status), 3'b101);
    clear_irq();
    fill(0, 2, DEPTH - 1, DEPTH - 1, -1, -1, 1'b0);
    chk("R10 load finished at full count", int'(irq), 1);
    chk("R8 status uncorrectable buf0", int'(status), 3'b010);
    rd(0, 1500);
    chk("R10 load contents intact", int'(rd_data), int'(pat(2, 0, 1500)));
    clear_irq();
  endtask

  task automatic t_auto();
    auto_clr = 1'b1;
    start(1);
    fill(1, 3, 0, DEPTH - 1, -1, -1, 1'b0);
    chk("R5 irq after buf1 fill", int'(irq), 1);
    chk("R8 status buf1 clean", int'(status), 3'b100);
    start(0);
    chk("R7 accepted start clears irq", int'(irq), 0);
    fill(0, 3, 0, DEPTH - 1, -1, -1, 1'b0);
    chk("R7 irq set again", int'(irq), 1);
    chk("R8 status buf0 clean", int'(status), 3'b000);
    rd(0, 100);
    chk("R1 read seed3 buf0", int'(rd_data), int'(pat(3, 0, 100)));
    auto_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fill_basic();
    t_busy_reject();
    t_idle_write();
    t_overlap();
    t_auto();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule